// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

A full-duplex asynchronous serial port with eight-entry byte queues in each direction. Software reaches it through a small byte-wide register bus. Writing the data register queues a byte for sending. Reading it returns the oldest received byte, and a read strobe removes that byte. The line format is set through a configuration register: seven or eight data bits, a parity mode (none, even, odd, or a forced-error mode for testing), and one or two stop bits. The same register enables an internal loopback and forces a break on the line. The bit rate comes from a programmable divisor that produces a 16x oversampling tick.

The receiver resynchronises the serial input. It takes each bit as the majority of three samples near mid-bit and throws away start bits that do not hold. It flags parity errors, framing errors, overrun and incoming breaks in sticky status bits, which software clears by writing ones. Eight interrupt sources, each with its own mask bit, are combined into a single interrupt line.

Register addresses: 0 data, 1 configuration, 2 status (a write clears flags), 3 interrupt mask, 4 divisor low byte, 5 divisor high byte. Other addresses read as zero.

Top module: `uart_fifo_core`

## Requirements
- R1: After reset the status register reads 0x04, the configuration and mask registers read 0x00, `txd` is high and `irq` is low. Status bits are: 0 receive queue not empty, 1 transmit queue full, 2 transmitter idle with an empty queue, 3 parity error, 4 framing error, 5 overrun, 6 break seen, 7 receive queue full.
- R2: Each serial bit lasts 16*(D+1) clock cycles, where D is the 16-bit divisor (low byte at address 4, high byte at address 5).
- R3: A character is a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Configuration bit 0 selects seven data bits (bit 7 is then neither sent nor kept) and bit 3 selects two stop bits. In loopback, every byte sent comes back unchanged, apart from the masked bit 7.
- R4: Configuration bits [2:1] select the parity: 0 none, 1 even, 2 odd. Characters sent and received with even or odd parity raise no parity error.
- R5: Parity mode 3 sends the inverse of even parity and checks for even parity, so every character received sets the parity error flag (status bit 3).
- R6: Each queue holds 8 bytes. After nine writes in a row with the line held busy, status bit 1 (transmit full) reads 1.
- R7: A character whose stop bit samples low, and whose bits are not all low, is stored and sets the framing flag (status bit 4).
- R8: When the line stays low through every bit position, including the stop bits, the receiver stores 0x00 and sets the break flag (status bit 6) rather than the framing flag.
- R9: When a character completes while the receive queue is full, that character is dropped, the stored bytes are kept, and the overrun flag (status bit 5) stays set until a write of 1 to status bit 5.
- R10: Each bit is the majority of the samples at oversample ticks 7, 8 and 9. A low pulse on the line that is high by mid-bit starts no character.
- R11: With configuration bit 4 set, the transmitter drives the receiver internally, `txd` stays high and `rxd` is ignored.
- R12: With configuration bit 5 set, the serial line is held low.
- R13: `irq` is the OR of the eight sources ANDed with the mask register. The sources are: bit 0 receive not empty, 1 receive full, 2 transmit queue empty, 3 transmit not full, 4 parity flag, 5 framing flag, 6 overrun flag, 7 break flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; at address 0 removes the oldest received byte |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest conditions to reach are the receive-side faults, because the transmitter only ever produces well-formed characters. The bench therefore drives `rxd` itself, one bit period at a time. It produces a low stop bit, a line held low for twelve bit times, and a glitch shorter than half a bit. Overrun is reached with the monitor switched off and nine characters looped back, so the ninth finds the receive queue full.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

    localparam int DIV_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {PAR_NONE, PAR_EVEN, PAR_ODD, PAR_FORCE} par_mode_e;

    // configuration register layout, bit 0 upwards: seven, par[2:1], two_stop, loop, send_brk
    typedef struct packed {
        logic      send_brk;
        logic      loop;
        logic      two_stop;
        par_mode_e par;
        logic      seven;
    } line_cfg_t;

    typedef enum logic [2:0] {SER_IDLE, SER_START, SER_DATA, SER_PAR, SER_STOP, SER_WAITHI} ser_state_e;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CFG  = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_MASK = 3'd3;
    localparam logic [2:0] A_DIVL = 3'd4;
    localparam logic [2:0] A_DIVH = 3'd5;

    function automatic logic data_parity(input logic [BYTE_W-1:0] d, input logic seven);
        return seven ? ^d[BYTE_W-2:0] : ^d;
    endfunction

    // parity bit placed on the wire; forced mode sends the wrong (odd) value
    function automatic logic wire_parity(input logic [BYTE_W-1:0] d, input logic seven,
                                         input par_mode_e m);
        return (m == PAR_EVEN) ? data_parity(d, seven) : ~data_parity(d, seven);
    endfunction

endpackage

// File: rtl/uart_baud.sv
module uart_baud
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q >= div);
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/uart_sfifo.sv
module uart_sfifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count
);
    typedef struct packed {
        logic [CW-1:0] wp;
        logic [CW-1:0] rp;
    } ptr_t;

    ptr_t             p_d, p_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             do_push, do_pop;

    always_comb begin
        count   = p_q.wp - p_q.rp;
        do_push = push && (count != CW'(DEPTH));
        do_pop  = pop && (count != '0);
        p_d     = p_q;
        if (do_push) p_d.wp = p_q.wp + 1'b1;
        if (do_pop)  p_d.rp = p_q.rp + 1'b1;
        dout    = mem[p_q.rp[AW-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[p_q.wp[AW-1:0]] <= din;
    end
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  line_cfg_t         cfg,
    input  logic              q_empty,
    input  logic [BYTE_W-1:0] q_data,
    output logic              q_pop,
    output logic              line,
    output logic              idle
);
    typedef struct packed {
        ser_state_e        st;
        logic [3:0]        cnt;
        logic [2:0]        idx;
        logic [BYTE_W-1:0] sh;
        logic              pbit;
        logic              stop2;
        logic              line;
    } tx_st_t;

    localparam tx_st_t TX_RST = '{st: SER_IDLE, cnt: '0, idx: '0, sh: '0,
                                  pbit: 1'b0, stop2: 1'b0, line: 1'b1};

    tx_st_t     s_d, s_q;
    logic [2:0] last_idx;

    always_comb begin
        s_d      = s_q;
        q_pop    = 1'b0;
        last_idx = cfg.seven ? 3'd6 : 3'd7;
        if (s_q.st == SER_IDLE) begin
            s_d.line = 1'b1;
            if (tick && !q_empty) begin
                q_pop     = 1'b1;
                s_d.sh    = q_data;
                s_d.pbit  = wire_parity(q_data, cfg.seven, cfg.par);
                s_d.cnt   = '0;
                s_d.st    = SER_START;
                s_d.line  = 1'b0;
            end
        end else if (tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == 4'd15) begin
                case (s_q.st)
                    SER_START: begin
                        s_d.line = s_q.sh[0];
                        s_d.sh   = s_q.sh >> 1;
                        s_d.idx  = '0;
                        s_d.st   = SER_DATA;
                    end
                    SER_DATA: begin
                        if (s_q.idx == last_idx) begin
                            s_d.stop2 = 1'b0;
                            if (cfg.par != PAR_NONE) begin
                                s_d.st   = SER_PAR;
                                s_d.line = s_q.pbit;
                            end else begin
                                s_d.st   = SER_STOP;
                                s_d.line = 1'b1;
                            end
                        end else begin
                            s_d.line = s_q.sh[0];
                            s_d.sh   = s_q.sh >> 1;
                            s_d.idx  = s_q.idx + 1'b1;
                        end
                    end
                    SER_PAR: begin
                        s_d.st   = SER_STOP;
                        s_d.line = 1'b1;
                    end
                    SER_STOP: begin
                        if (cfg.two_stop && !s_q.stop2) s_d.stop2 = 1'b1;
                        else                            s_d.st    = SER_IDLE;
                    end
                    default: s_d.st = SER_IDLE;
                endcase
            end
        end
        line = s_q.line;
        idle = (s_q.st == SER_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= TX_RST;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_rx_ser.sv
module uart_rx_ser
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  line_cfg_t         cfg,
    input  logic              line_in,
    output logic              evt,
    output logic [BYTE_W-1:0] data,
    output logic              par_err,
    output logic              frm_err,
    output logic              brk
);
    typedef struct packed {
        ser_state_e        st;
        logic [3:0]        cnt;
        logic [1:0]        ones;
        logic [2:0]        idx;
        logic [BYTE_W-1:0] sh;
        logic              pbit;
        logic              allz;
        logic              bad;
        logic              stop2;
    } rx_st_t;

    localparam rx_st_t RX_RST = '{st: SER_IDLE, cnt: '0, ones: '0, idx: '0, sh: '0,
                                  pbit: 1'b0, allz: 1'b0, bad: 1'b0, stop2: 1'b0};

    rx_st_t     s_d, s_q;
    logic [1:0] vote;
    logic       bitv, allz_fin, par_bad;
    logic [2:0] last_idx;

    always_comb begin
        s_d      = s_q;
        evt      = 1'b0;
        par_err  = 1'b0;
        frm_err  = 1'b0;
        brk      = 1'b0;
        last_idx = cfg.seven ? 3'd6 : 3'd7;
        vote     = s_q.ones + {1'b0, line_in};
        bitv     = vote[1];
        allz_fin = s_q.allz && !bitv;
        data     = cfg.seven ? {1'b0, s_q.sh[BYTE_W-1:1]} : s_q.sh;
        case (cfg.par)
            PAR_EVEN, PAR_FORCE: par_bad = data_parity(data, cfg.seven) ^ s_q.pbit;
            PAR_ODD:             par_bad = ~(data_parity(data, cfg.seven) ^ s_q.pbit);
            default:             par_bad = 1'b0;
        endcase
        case (s_q.st)
            SER_IDLE: begin
                if (tick && !line_in) begin
                    s_d.st   = SER_START;
                    s_d.cnt  = 4'd1;
                    s_d.sh   = '0;
                    s_d.allz = 1'b1;
                    s_d.bad  = 1'b0;
                    s_d.ones = '0;
                end
            end
            SER_WAITHI: begin
                if (line_in) s_d.st = SER_IDLE;
            end
            default: begin
                if (tick) begin
                    s_d.cnt = s_q.cnt + 1'b1;
                    if (s_q.cnt == 4'd7) s_d.ones = {1'b0, line_in};
                    if (s_q.cnt == 4'd8) s_d.ones = vote;
                    if (s_q.cnt == 4'd9) begin
                        case (s_q.st)
                            SER_START: if (bitv) s_d.st = SER_IDLE;
                            SER_DATA: begin
                                s_d.sh   = {bitv, s_q.sh[BYTE_W-1:1]};
                                s_d.allz = allz_fin;
                            end
                            SER_PAR: begin
                                s_d.pbit = bitv;
                                s_d.allz = allz_fin;
                            end
                            SER_STOP: begin
                                s_d.allz = allz_fin;
                                s_d.bad  = s_q.bad || !bitv;
                                if (!cfg.two_stop || s_q.stop2) begin
                                    evt     = 1'b1;
                                    brk     = allz_fin;
                                    frm_err = !allz_fin && (s_q.bad || !bitv);
                                    par_err = !allz_fin && par_bad;
                                    s_d.st  = bitv ? SER_IDLE : SER_WAITHI;
                                end
                            end
                            default: s_d.st = SER_IDLE;
                        endcase
                    end
                    if (s_q.cnt == 4'd15) begin
                        case (s_q.st)
                            SER_START: begin
                                s_d.st  = SER_DATA;
                                s_d.idx = '0;
                            end
                            SER_DATA: begin
                                if (s_q.idx == last_idx) begin
                                    s_d.st    = (cfg.par != PAR_NONE) ? SER_PAR : SER_STOP;
                                    s_d.stop2 = 1'b0;
                                end else begin
                                    s_d.idx = s_q.idx + 1'b1;
                                end
                            end
                            SER_PAR: begin
                                s_d.st    = SER_STOP;
                                s_d.stop2 = 1'b0;
                            end
                            SER_STOP: s_d.stop2 = 1'b1;
                            default:  s_d.st    = SER_IDLE;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RX_RST;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_fifo_core.sv
module uart_fifo_core
    import uart_fifo_pkg::*;
#(
    parameter int               FIFO_DEPTH = 8,
    parameter logic [DIV_W-1:0] DIV_RESET  = 16'd26
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq
);
    localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

    typedef struct packed {
        line_cfg_t        cfg;
        logic [7:0]       mask;
        logic [DIV_W-1:0] div;
        logic             par_f;
        logic             frm_f;
        logic             ovr_f;
        logic             brk_f;
        logic [1:0]       sync;
    } regs_t;

    localparam regs_t REGS_RST = '{cfg: '0, mask: '0, div: DIV_RESET, par_f: 1'b0,
                                   frm_f: 1'b0, ovr_f: 1'b0, brk_f: 1'b0, sync: 2'b11};

    regs_t              r_d, r_q;
    logic               tick;
    logic               tx_push, tx_pop, tx_empty, tx_full, tx_ser_idle, tx_line, tx_idle;
    logic [BYTE_W-1:0]  tx_head, rx_head, rx_data;
    logic [CNT_W-1:0]   tx_count, rx_count;
    logic               rx_pop, rx_empty, rx_full, rx_evt, rx_pe, rx_fe, rx_bk, rx_push;
    logic               rx_line, line_int, loop_en, brk_en;
    logic [7:0]         status, irq_src;

    uart_baud u_baud (.clk(clk), .rst_n(rst_n), .div(r_q.div), .tick(tick));

    uart_sfifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wdata),
        .pop(tx_pop), .dout(tx_head), .count(tx_count));

    uart_sfifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_data),
        .pop(rx_pop), .dout(rx_head), .count(rx_count));

    uart_tx_ser u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(r_q.cfg), .q_empty(tx_empty),
        .q_data(tx_head), .q_pop(tx_pop), .line(tx_line), .idle(tx_ser_idle));

    uart_rx_ser u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cfg(r_q.cfg), .line_in(rx_line),
        .evt(rx_evt), .data(rx_data), .par_err(rx_pe), .frm_err(rx_fe), .brk(rx_bk));

    always_comb begin
        loop_en  = r_q.cfg.loop;
        brk_en   = r_q.cfg.send_brk;
        tx_empty = (tx_count == '0);
        tx_full  = (tx_count == CNT_W'(FIFO_DEPTH));
        rx_empty = (rx_count == '0);
        rx_full  = (rx_count == CNT_W'(FIFO_DEPTH));
        tx_idle  = tx_ser_idle && tx_empty;
        line_int = tx_line && !brk_en;
        rx_line  = loop_en ? line_int : r_q.sync[1];
        txd      = loop_en ? 1'b1 : line_int;
        tx_push  = wr_en && (addr == A_DATA) && !tx_full;
        rx_pop   = rd_en && (addr == A_DATA) && !rx_empty;
        rx_push  = rx_evt && !rx_full;

        status  = {rx_full, r_q.brk_f, r_q.ovr_f, r_q.frm_f, r_q.par_f, tx_idle, tx_full, !rx_empty};
        irq_src = {r_q.brk_f, r_q.ovr_f, r_q.frm_f, r_q.par_f, !tx_full, tx_empty, rx_full, !rx_empty};
        irq     = |(irq_src & r_q.mask);

        case (addr)
            A_DATA:  rdata = rx_head;
            A_CFG:   rdata = {2'b00, r_q.cfg};
            A_STAT:  rdata = status;
            A_MASK:  rdata = r_q.mask;
            A_DIVL:  rdata = r_q.div[7:0];
            A_DIVH:  rdata = r_q.div[DIV_W-1:8];
            default: rdata = '0;
        endcase

        r_d      = r_q;
        r_d.sync = {r_q.sync[0], rxd};
        if (wr_en) begin
            case (addr)
                A_CFG:  r_d.cfg             = line_cfg_t'(wdata[5:0]);
                A_MASK: r_d.mask            = wdata;
                A_DIVL: r_d.div[7:0]        = wdata;
                A_DIVH: r_d.div[DIV_W-1:8]  = wdata[DIV_W-9:0];
                A_STAT: begin
                    if (wdata[3]) r_d.par_f = 1'b0;
                    if (wdata[4]) r_d.frm_f = 1'b0;
                    if (wdata[5]) r_d.ovr_f = 1'b0;
                    if (wdata[6]) r_d.brk_f = 1'b0;
                end
                default: ;
            endcase
        end
        if (rx_evt) begin
            if (rx_pe)   r_d.par_f = 1'b1;
            if (rx_fe)   r_d.frm_f = 1'b1;
            if (rx_bk)   r_d.brk_f = 1'b1;
            if (rx_full) r_d.ovr_f = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_RST;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/uart_fifo_chk.sv
module uart_fifo_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [2:0]    addr,
    input logic [7:0]    wdata,
    input logic          txd,
    input logic          irq,
    input logic [7:0]    mask,
    input logic          loop_en,
    input logic          brk_en,
    input logic          tx_idle,
    input logic          rx_evt,
    input logic          rx_full,
    input logic          rx_pop,
    input logic [CW-1:0] rx_count,
    input logic          ovr_f
);
    logic ovr_clr;
    assign ovr_clr = wr_en && (addr == 3'd2) && wdata[5];

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !brk_en && !loop_en) |-> txd);                              // R3
    AST_LOOP_TXD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> txd);                                                       // R11
    AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));                                                // R6
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_f && !ovr_clr) |=> ovr_f);                                         // R9
    AST_OVR_KEEPS_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && rx_full && !rx_pop) |=> (rx_count == $past(rx_count)));      // R9
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == 8'h00) |-> !irq);                                              // R13
endmodule

bind uart_fifo_core uart_fifo_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .txd(txd), .irq(irq), .mask(r_q.mask), .loop_en(loop_en), .brk_en(brk_en),
    .tx_idle(tx_idle), .rx_evt(rx_evt), .rx_full(rx_full), .rx_pop(rx_pop),
    .rx_count(rx_count), .ovr_f(r_q.ovr_f));

// File: tb/uart_fifo_core_tb.sv
module uart_fifo_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;

    int         checks = 0, failures = 0;
    bit         bus_busy = 1'b0;
    bit         mon_en = 1'b0;
    logic [7:0] exp_q[$];
    localparam int BITCLK = 32;   // divisor 1 -> 16*2 clocks per bit

    always #10 clk = ~clk;

    uart_fifo_core u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq));

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_get();
        while (bus_busy) @(negedge clk);
        bus_busy = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_get();
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        bus_busy = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_get();
        @(negedge clk);
        addr = a;
        #1 d = rdata;
        bus_busy = 1'b0;
    endtask

    task automatic pop(output logic [7:0] d);
        bus_get();
        @(negedge clk);
        addr = 3'd0;
        #1 d = rdata;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        bus_busy = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic [7:0] expected);
        exp_q.push_back(expected);
        wr(3'd0, b);
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd2, s);
            if (s[2]) break;
        end
        repeat (40) @(negedge clk);
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 20000; i++) begin
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        wait_idle();
    endtask

    task automatic drive_bits(input logic v, input int nbits);
        rxd = v;
        repeat (nbits * BITCLK) @(negedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] b, input logic stopv);
        drive_bits(1'b0, 1);
        for (int i = 0; i < 8; i++) drive_bits(b[i], 1);
        drive_bits(stopv, 1);
        drive_bits(1'b1, 2);
    endtask

    // scoreboard monitor
    initial begin
        logic [7:0] s, v, e;
        forever begin
            @(negedge clk);
            if (mon_en) begin
                rd(3'd2, s);
                if (s[0]) begin
                    pop(v);
                    if (exp_q.size() == 0) begin
                        check("R3 unexpected byte", v, 256);
                    end else begin
                        e = exp_q.pop_front();
                        check("R3 loopback byte", v, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] s, v;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(3'd2, s); check("R1 status after reset", s, 8'h04);
        rd(3'd1, s); check("R1 config after reset", s, 8'h00);
        rd(3'd3, s); check("R1 mask after reset", s, 8'h00);
        check("R1 txd idle high", txd, 1);
        check("R1 irq low", irq, 0);

        wr(3'd4, 8'h01);
        wr(3'd5, 8'h00);

        // R2 bit time: start bit then data bit0=1
        wr(3'd0, 8'h01);
        while (txd !== 1'b0) @(negedge clk);
        n = 0;
        while (txd === 1'b0 && n < 1000) begin n++; @(negedge clk); end
        check("R2 start bit length in clocks", n, BITCLK);
        wait_idle();

        // R3 8N1 loopback, R11 rxd ignored and txd high
        wr(3'd1, 8'h10);
        mon_en = 1'b1;
        rxd = 1'b0;
        send(8'h55, 8'h55);
        send(8'hA3, 8'hA3);
        repeat (50) @(negedge clk);
        check("R11 txd high in loopback", txd, 1);
        send(8'h00, 8'h00);
        send(8'hFF, 8'hFF);
        wait_drain();
        rxd = 1'b1;
        rd(3'd2, s); check("R3 no error flags 8N1", s & 8'h78, 0);

        // R3/R4 seven bits, even parity, two stops
        wr(3'd1, 8'h1B);
        send(8'hC5, 8'h45);
        send(8'h7F, 8'h7F);
        wait_drain();
        rd(3'd2, s); check("R4 even parity no error", s & 8'h78, 0);

        // R4 odd parity
        wr(3'd1, 8'h14);
        send(8'h3C, 8'h3C);
        send(8'h81, 8'h81);
        wait_drain();
        rd(3'd2, s); check("R4 odd parity no error", s & 8'h78, 0);

        // R5 forced parity error
        wr(3'd1, 8'h16);
        send(8'h5A, 8'h5A);
        wait_drain();
        rd(3'd2, s); check("R5 forced parity flag", s[3], 1);
        wr(3'd2, 8'h78);
        rd(3'd2, s); check("R5 flags cleared by write", s & 8'h78, 0);
        mon_en = 1'b0;
        repeat (4) @(negedge clk);

        // R6 transmit queue full
        wr(3'd1, 8'h00);
        for (int i = 0; i < 9; i++) wr(3'd0, 8'(8'h20 + i));
        rd(3'd2, s); check("R6 transmit full", s[1], 1);
        wait_idle();

        // R9 overrun
        wr(3'd1, 8'h10);
        wr(3'd0, 8'h10);
        repeat (4) @(negedge clk);
        for (int i = 1; i < 9; i++) wr(3'd0, 8'(8'h10 + i));
        wait_idle();
        rd(3'd2, s); check("R9 overrun and full flags", s & 8'hA1, 8'hA1);
        for (int i = 0; i < 8; i++) begin
            pop(v); check("R9 kept byte", v, 8'h10 + i);
        end
        rd(3'd2, s); check("R9 ninth byte dropped, overrun sticky", s & 8'h21, 8'h20);
        wr(3'd2, 8'h20);
        rd(3'd2, s); check("R9 overrun cleared", s[5], 0);

        // R13 interrupt masking
        wr(3'd3, 8'h01);
        check("R13 irq low with empty queue", irq, 0);
        wr(3'd0, 8'h42);
        wait_idle();
        check("R13 irq on receive", irq, 1);
        wr(3'd3, 8'h00);
        @(negedge clk);
        check("R13 irq masked off", irq, 0);
        pop(v); check("R13 received byte", v, 8'h42);

        // R10 noise glitch on external line
        wr(3'd1, 8'h00);
        rxd = 1'b0;
        repeat (6) @(negedge clk);
        rxd = 1'b1;
        repeat (600) @(negedge clk);
        rd(3'd2, s); check("R10 glitch ignored", s & 8'h11, 0);

        // R7 framing error
        rx_frame(8'hA5, 1'b0);
        rd(3'd2, s); check("R7 framing flag", s & 8'h51, 8'h11);
        pop(v); check("R7 byte stored", v, 8'hA5);
        wr(3'd2, 8'h78);

        // R8 break detection
        drive_bits(1'b0, 12);
        drive_bits(1'b1, 2);
        rd(3'd2, s); check("R8 break flag without framing", s & 8'h51, 8'h41);
        pop(v); check("R8 break byte", v, 8'h00);
        wr(3'd2, 8'h78);

        // R12 break transmit
        wr(3'd1, 8'h20);
        @(negedge clk);
        check("R12 line held low", txd, 0);
        wr(3'd1, 8'h00);
        @(negedge clk);
        check("R12 line released", txd, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule